// File: doc/BRIEF.md
# Pipelined Static-RAM Slave with Ready Countdown

This block sits between a single pipelined bus master and an external asynchronous static RAM. The master starts a transfer with a one-cycle read or write strobe. The strobe carries an address and, for a write, the data. The slave then drives the RAM chip-enable, output-enable, write-enable, address and data lines through a fixed sequence of phases. It reports its progress on a 2-bit ready countdown.

The countdown gives the number of clock edges still needed before the current transfer is finished. A master can therefore start its own downstream work one cycle before read data lands. The countdown also acts as the only flow control. A new strobe is taken when the countdown reads 0 or 1. A strobe at any other time has no effect. When a read is strobed while the previous read shows 1, the slave captures the old data and launches the new address on the same edge. Back-to-back reads therefore place a new RAM address every second clock, which matches a two-cycle RAM access.

The last read result stays on the read-data register until a later read captures new data. The slave never starts a transfer by itself.

Top module: `pipe_sram_slave`

## Requirements
- R1: While reset is held and right after it, the read data is zero, the countdown is 0, chip-enable, output-enable and write-enable are all high (inactive), and the slave does not drive the RAM data lines.
- R2: An accepted read places the sampled address on the RAM with chip-enable and output-enable low. The countdown then reads 2, then 1, then 0. Read data from the RAM is captured on the edge where the countdown goes from 1 to 0.
- R3: The countdown encoding is as follows. 0 means the transfer is finished. 1 and 2 give the number of edges left. 3 means three or more edges are left. Each non-zero value steps down by one on every edge, unless a new transfer starts.
- R4: A strobe is accepted only while the countdown is 0 or 1. A strobe raised while it is 2 or 3 is ignored: the RAM address does not change and no transfer follows. The address and write data are sampled only on the accepted strobe cycle.
- R5: A read strobed while the countdown is 1 starts on the same edge that completes the current read or write. For two pipelined reads, the RAM address changes exactly two clocks after the first one was presented.
- R6: An accepted write runs three phases, all with chip-enable low, address and data driven, and output-enable high. The first is a setup cycle with write-enable high and countdown 3. The second is a pulse cycle with write-enable low and countdown 2. The third is a hold cycle with write-enable high, countdown 1, and address and data unchanged.
- R7: The read data changes only when a read completes. Writes, ignored strobes and idle cycles leave it unchanged.
- R8: If read and write strobes arrive together on an accepted cycle, the write is performed and the read is dropped.
- R9: Output-enable is never low while the slave drives the data lines. Write-enable is low only while chip-enable is low, output-enable is high and data is driven.
- R10: With the countdown at 0 and no strobe, the slave stays idle with chip-enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | One-cycle read strobe |
| wr_req | input | 1 | One-cycle write strobe |
| addr | input | ADDR_W | Word address, sampled on an accepted strobe |
| wr_data | input | DATA_W | Write data, sampled on an accepted write strobe |
| rd_data | output | DATA_W | Last captured read result |
| rdy_cnt | output | 2 | Edges remaining until the transfer is finished |
| mem_addr | output | ADDR_W | RAM address lines |
| mem_wdata | output | DATA_W | Data driven toward the RAM |
| mem_rdata | input | DATA_W | Data returned by the RAM |
| mem_drive | output | 1 | High while the slave drives the RAM data lines |
| mem_ce_n | output | 1 | RAM chip-enable, active low |
| mem_oe_n | output | 1 | RAM output-enable, active low |
| mem_we_n | output | 1 | RAM write-enable, active low |

## Verification
The checker watches the following on every cycle:
- the RAM control lines for bus contention and for a badly qualified write-enable;
- the one-cycle width of the write pulse;
- the countdown stepping down from 3 and 2;
- the address staying still while a strobe would be refused;
- idle staying idle;
- the read register holding except at a read completion.

Only the directed scenarios can show that the data captured is the word at the requested address, and that a write really reaches the RAM. They also show that pipelined reads hand over on the shared edge, and that a refused strobe leaves no trace once the transfer ends.

// File: rtl/pipe_sram_slave.sv
module pipe_sram_slave #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rdy_cnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_drive,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n
);

  typedef enum logic [2:0] {IDLE, RD_A, RD_B, WR_SET, WR_PLS, WR_HLD} phase_t;

  phase_t ph, ph_nx;
  logic   take, start_wr, start_rd;

  assign take     = (rdy_cnt <= 2'd1);
  assign start_wr = take & wr_req;
  assign start_rd = take & rd_req & ~wr_req;

  always_comb begin
    case (ph)
      RD_A:    rdy_cnt = 2'd2;
      RD_B:    rdy_cnt = 2'd1;
      WR_SET:  rdy_cnt = 2'd3;
      WR_PLS:  rdy_cnt = 2'd2;
      WR_HLD:  rdy_cnt = 2'd1;
      default: rdy_cnt = 2'd0;
    endcase
  end

  always_comb begin
    if (start_wr)      ph_nx = WR_SET;
    else if (start_rd) ph_nx = RD_A;
    else begin
      case (ph)
        RD_A:    ph_nx = RD_B;
        WR_SET:  ph_nx = WR_PLS;
        WR_PLS:  ph_nx = WR_HLD;
        default: ph_nx = IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= IDLE;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rd_data   <= '0;
    end else begin
      ph <= ph_nx;
      if (start_wr || start_rd) mem_addr  <= addr;
      if (start_wr)             mem_wdata <= wr_data;
      if (ph == RD_B)           rd_data   <= mem_rdata;
    end
  end

  assign mem_ce_n  = (ph == IDLE);
  assign mem_oe_n  = !(ph == RD_A || ph == RD_B);
  assign mem_we_n  = (ph != WR_PLS);
  assign mem_drive = (ph == WR_SET || ph == WR_PLS || ph == WR_HLD);

endmodule

// File: rtl/pipe_sram_slave_chk.sv
module pipe_sram_slave_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              wr_req,
  input logic [1:0]        rdy_cnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              mem_drive,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n
);

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && mem_drive)); // R9

  AST_WE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_drive)); // R9

  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |=> $rose(mem_we_n)); // R6

  AST_COUNT_FROM_3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_cnt == 2'd3) |=> (rdy_cnt == 2'd2)); // R3

  AST_COUNT_FROM_2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_cnt == 2'd2) |=> (rdy_cnt == 2'd1)); // R3

  AST_BUSY_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_cnt >= 2'd2) |=> $stable(mem_addr)); // R4

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_cnt <= 2'd1 && wr_req) |=> (rdy_cnt == 2'd3 && mem_oe_n)); // R8

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_cnt == 2'd0 && !rd_req && !wr_req) |=> (rdy_cnt == 2'd0 && mem_ce_n)); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_cnt != 2'd1) |=> $stable(rd_data)); // R7

endmodule

bind pipe_sram_slave pipe_sram_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .rdy_cnt(rdy_cnt),
  .mem_addr(mem_addr), .rd_data(rd_data), .mem_drive(mem_drive),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
);

// File: tb/tb_pipe_sram_slave.sv
`timescale 1ns/1ps
module tb_pipe_sram_slave;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, rd_req, wr_req;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data, rd_data, mem_wdata, mem_rdata;
  logic [1:0] rdy_cnt;
  logic [AW-1:0] mem_addr;
  logic mem_drive, mem_ce_n, mem_oe_n, mem_we_n;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] ram [DEPTH];
  logic [DW-1:0] shadow [DEPTH];

  always #4 clk = ~clk;

  pipe_sram_slave #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rdy_cnt(rdy_cnt), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_drive(mem_drive),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
  );

  function automatic logic [DW-1:0] pat(int i);
    return DW'((i * 16'h3b1) ^ 16'h5a00);
  endfunction

  assign mem_rdata = (!mem_ce_n && !mem_oe_n) ? ram[mem_addr] : '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= pat(i);
    end else if (!mem_ce_n && !mem_we_n && mem_drive) begin
      ram[mem_addr] <= mem_wdata;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe_rd(logic [AW-1:0] a);
    rd_req = 1'b1; addr = a;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rd_req = 1'b0; wr_req = 1'b0; addr = '0; wr_data = '0;
    for (int i = 0; i < DEPTH; i++) shadow[i] = pat(i);
    repeat (3) @(negedge clk);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 rdy_cnt", rdy_cnt, 0);
    chk("R1 ctrl ce/oe/we", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    chk("R1 drive", mem_drive, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {rdy_cnt, mem_ce_n}, 3'b001);
  endtask

  task automatic t_read(logic [AW-1:0] a);
    strobe_rd(a);
    @(negedge clk); rd_req = 1'b0;
    chk("R2 cnt after strobe", rdy_cnt, 2);
    chk("R2 ce/oe low", {mem_ce_n, mem_oe_n}, 2'b00);
    chk("R2 address", mem_addr, a);
    @(negedge clk);
    chk("R2 cnt 1", rdy_cnt, 1);
    @(negedge clk);
    chk("R2 cnt 0", rdy_cnt, 0);
    chk("R2 data", rd_data, shadow[a]);
  endtask

  task automatic t_idle();
    logic [DW-1:0] held;
    held = rd_data;
    repeat (4) @(negedge clk);
    chk("R10 idle cnt", rdy_cnt, 0);
    chk("R10 idle ce", mem_ce_n, 1);
    chk("R7 idle hold", rd_data, held);
  endtask

  task automatic t_pipe(logic [AW-1:0] a, logic [AW-1:0] b);
    strobe_rd(a);
    @(negedge clk); rd_req = 1'b0;
    @(negedge clk);
    chk("R5 cnt before second", rdy_cnt, 1);
    chk("R5 first addr held", mem_addr, a);
    strobe_rd(b);
    @(negedge clk); rd_req = 1'b0;
    chk("R5 first data", rd_data, shadow[a]);
    chk("R5 second addr two clocks later", mem_addr, b);
    chk("R5 cnt restart", rdy_cnt, 2);
    @(negedge clk);
    @(negedge clk);
    chk("R5 second done", rdy_cnt, 0);
    chk("R5 second data", rd_data, shadow[b]);
  endtask

  task automatic t_ignore(logic [AW-1:0] a, logic [AW-1:0] b);
    strobe_rd(a);
    @(negedge clk);
    chk("R4 busy cnt", rdy_cnt, 2);
    addr = b;
    @(negedge clk); rd_req = 1'b0;
    chk("R4 addr unchanged", mem_addr, a);
    chk("R4 cnt 1", rdy_cnt, 1);
    @(negedge clk);
    chk("R4 data of first", rd_data, shadow[a]);
    @(negedge clk);
    chk("R4 no later transfer", {rdy_cnt, mem_ce_n}, 3'b001);
  endtask

  task automatic t_write(logic [AW-1:0] a, logic [DW-1:0] d);
    logic [DW-1:0] held;
    held = rd_data;
    wr_req = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_req = 1'b0; addr = a + 1'b1; wr_data = ~d;
    chk("R3 cnt 3 in setup", rdy_cnt, 3);
    chk("R6 setup ctrl ce/oe/we/drv", {mem_ce_n, mem_oe_n, mem_we_n, mem_drive}, 4'b0111);
    chk("R4 addr sampled on strobe", mem_addr, a);
    chk("R4 data sampled on strobe", mem_wdata, d);
    @(negedge clk);
    chk("R6 pulse we", mem_we_n, 0);
    chk("R6 pulse cnt", rdy_cnt, 2);
    @(negedge clk);
    chk("R6 hold we/cnt", {mem_we_n, rdy_cnt}, 3'b101);
    chk("R6 hold addr", mem_addr, a);
    chk("R6 hold data", mem_wdata, d);
    shadow[a] = d;
    @(negedge clk);
    chk("R6 done", {rdy_cnt, mem_drive, mem_ce_n}, 4'b0001);
    chk("R7 write keeps rd_data", rd_data, held);
  endtask

  task automatic t_both(logic [AW-1:0] a, logic [DW-1:0] d);
    wr_req = 1'b1; rd_req = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_req = 1'b0; rd_req = 1'b0;
    chk("R8 write taken", rdy_cnt, 3);
    chk("R8 oe high", mem_oe_n, 1);
    repeat (3) @(negedge clk);
    shadow[a] = d;
    chk("R8 finished", rdy_cnt, 0);
    t_read(a);
  endtask

  task automatic t_write_then_read(logic [AW-1:0] a, logic [DW-1:0] d);
    wr_req = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 hold cnt", rdy_cnt, 1);
    strobe_rd(a);
    shadow[a] = d;
    @(negedge clk); rd_req = 1'b0;
    chk("R5 read after write starts", {rdy_cnt, mem_oe_n, mem_drive}, 4'b1000);
    repeat (2) @(negedge clk);
    chk("R5 read-after-write data", rd_data, d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_read(8'h15);
    t_idle();
    t_pipe(8'h20, 8'h21);
    t_pipe(8'hfe, 8'h03);
    t_ignore(8'h40, 8'h41);
    t_write(8'h40, 16'hbeef);
    t_read(8'h40);
    t_both(8'h77, 16'h1234);
    t_write_then_read(8'h90, 16'hc0de);
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule